// File: doc/BRIEF.md
# Receive Frame Completion Status Tracker

This block follows each received frame on a byte stream from its first byte to its last. It counts the bytes of the frame in a saturating length counter and compares the running count against a programmable maximum length. A frame that grows past the maximum is never cut short. Every accepted byte is forwarded one cycle later on a pass-through output. When the count first exceeds the limit, a babbling-receiver event is raised and the frame is marked long.

When the end byte has been taken in, the block spends one cycle committing a status word. The word carries the saturated length, the long-frame flag, a last-buffer flag that is set, and an ownership (empty) flag that is cleared. On the following cycle it raises a frame-received event and returns to idle to wait for the next start strobe. The two events are sticky and are cleared by writing 1. Each event has its own mask bit, and the interrupt line is the OR of the enabled events.

The stream rules are as follows. A frame begins with a beat that has both valid and start high while the block is idle. It ends with a valid beat that has end high; that beat may be the start beat itself. The producer leaves at least one cycle between an end beat and the next start beat.

Top module: `rx_frame_status`

## Requirements
- R1: Every byte of a frame, including every byte beyond the maximum length, appears on `pass_data` with `pass_valid` high exactly one cycle after it is accepted, in order, so that a frame of N bytes yields N pass-through beats.
- R2: The status word holds the frame length in bits [10:0] and the long flag in bit 11. Bit 11 is 1 exactly when the length exceeds `cfg_max_len`.
- R3: `ev_babble` is set in the cycle after the byte that takes the count to `cfg_max_len`+1 is accepted, and not before. Once it is cleared during the same frame, it is not set again by later bytes of that frame.
- R4: `st_wr` is a one-cycle pulse in the cycle after the end beat is accepted. With it, the status word has bit 12 (last) = 1, bit 13 (empty/owned) = 0 and bits [15:14] = 0.
- R5: `ev_frame` is 0 during the `st_wr` cycle, given it was clear before, and becomes 1 in the next cycle. It never rises without `st_wr` in the cycle before.
- R6: `irq` = (`ev_frame` AND `mask_frame`) OR (`ev_babble` AND `mask_babble`).
- R7: Writing 1 to `clr_frame` or `clr_babble` clears that event on the next edge. When a set and a clear of the same event meet in one cycle, the set wins.
- R8: The length counter saturates at 2047 and does not wrap, so a frame of 2047 or more bytes reports length 2047.
- R9: While idle, beats without a start strobe, including beats with an end strobe, are ignored: no pass-through beat, no status write, no event.
- R10: During and right after reset, `st_wr`, `pass_valid`, both events and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_sof | input | 1 | Valid byte is the first of a frame |
| in_eof | input | 1 | Valid byte is the last of a frame |
| in_data | input | 8 | Received byte |
| cfg_max_len | input | 11 | Maximum frame length in bytes |
| mask_frame | input | 1 | Enables the frame-received event onto `irq` |
| mask_babble | input | 1 | Enables the babbling-receiver event onto `irq` |
| clr_frame | input | 1 | Write-1-to-clear for `ev_frame` |
| clr_babble | input | 1 | Write-1-to-clear for `ev_babble` |
| pass_valid | output | 1 | Forwarded byte is valid |
| pass_data | output | 8 | Forwarded byte |
| st_wr | output | 1 | Status word write strobe |
| st_word | output | 16 | Frame status word |
| ev_frame | output | 1 | Sticky frame-received event |
| ev_babble | output | 1 | Sticky babbling-receiver event |
| irq | output | 1 | Masked interrupt line |

## Verification
Two functions can fall in the same cycle: the hardware setting an event and software clearing it. The bench provokes this by holding `clr_frame` high during the very cycle in which `st_wr` is high. That is the cycle whose closing edge sets `ev_frame`. The test is judged correct only if `ev_frame` reads 1 afterwards. A second overlap is the babble clear arriving mid-frame while later oversize bytes keep streaming; there `ev_babble` must stay 0 to the end of that frame.

// File: rtl/rxst_pkg.sv
// Package: shared types and constants of the receive frame status tracker.
// Assumes: nothing; holds only declarations.
package rxst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECV   = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_t;

    localparam int EV_FRAME  = 0;
    localparam int EV_BABBLE = 1;
    localparam int EV_COUNT  = 2;
endpackage

// File: rtl/rxst_len_counter.sv
// Module: saturating frame length counter with oversize detection.
// Produces the count and long flag that include the current beat, and a
//   single-cycle babble pulse on the first beat that passes the limit.
// Assumes: beat_first and beat_more are never high together.
module rxst_len_counter #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_first,
    input  logic             beat_more,
    input  logic [LEN_W-1:0] max_len,
    output logic [LEN_W-1:0] cnt_nx,
    output logic             long_nx,
    output logic             babble_pulse
);
    localparam logic [LEN_W-1:0] CNT_TOP = {LEN_W{1'b1}};
    localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

    logic [LEN_W-1:0] cnt_q;
    logic             long_q;
    logic             long_base;
    logic             over;

    // Next count and long flag for the beat presented this cycle.
    always_comb begin
        if (beat_first) begin
            cnt_nx    = CNT_ONE;
            long_base = 1'b0;
        end else if (beat_more) begin
            cnt_nx    = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + CNT_ONE;
            long_base = long_q;
        end else begin
            cnt_nx    = cnt_q;
            long_base = long_q;
        end
        over         = (beat_first || beat_more) && (cnt_nx > max_len);
        long_nx      = long_base || over;
        babble_pulse = over && !long_base;
    end

    // Holds the running count and long flag between beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            long_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nx;
            long_q <= long_nx;
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_more && !beat_first && cnt_q == CNT_TOP) |=> (cnt_q == CNT_TOP)); // R8
    AST_BABBLE_MARKS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        babble_pulse |=> long_q); // R3
endmodule

// File: rtl/rxst_frame_seq.sv
// Module: frame sequencer; qualifies beats, captures the status word on the
//   end beat, and strobes it for one cycle before signalling completion.
// Assumes: at least one idle cycle between an end beat and the next start.
module rxst_frame_seq
    import rxst_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int STW   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [LEN_W-1:0] cnt_nx,
    input  logic             long_nx,
    output logic             beat_first,
    output logic             beat_more,
    output logic             st_wr,
    output logic [STW-1:0]   st_word,
    output logic             frame_done
);
    localparam int BIT_LONG  = LEN_W;
    localparam int BIT_LAST  = LEN_W + 1;
    localparam int BIT_EMPTY = LEN_W + 2;

    seq_state_t     state_q, state_nx;
    logic           end_beat;
    logic [STW-1:0] word_q;

    // Beat qualification against the current state.
    always_comb begin
        beat_first = in_valid && in_sof && (state_q == ST_IDLE);
        beat_more  = in_valid && (state_q == ST_RECV);
        end_beat   = (beat_first || beat_more) && in_eof;
    end

    // Next-state decision.
    always_comb begin
        state_nx = state_q;
        case (state_q)
            ST_IDLE:   if (beat_first) state_nx = end_beat ? ST_COMMIT : ST_RECV;
            ST_RECV:   if (end_beat)   state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register and status capture on the end beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_nx;
            if (end_beat) begin
                word_q             <= '0;
                word_q[LEN_W-1:0]  <= cnt_nx;
                word_q[BIT_LONG]   <= long_nx;
                word_q[BIT_LAST]   <= 1'b1;
                word_q[BIT_EMPTY]  <= 1'b0;
            end
        end
    end

    assign st_wr      = (state_q == ST_COMMIT);
    assign frame_done = (state_q == ST_COMMIT);
    assign st_word    = word_q;

    AST_STWR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> !st_wr); // R4
    AST_STWR_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_wr) |-> $past(in_valid && in_eof)); // R4
endmodule

// File: rtl/rxst_events.sv
// Module: sticky event bits with write-1-to-clear, per-event masks and an
//   ORed interrupt line. A set beats a clear in the same cycle.
// Assumes: set inputs are single-cycle pulses from the sequencer/counter.
module rxst_events #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_set,
    input  logic [N-1:0] ev_clr,
    input  logic [N-1:0] ev_mask,
    output logic [N-1:0] ev_q,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_ev
        // One sticky event bit.
        always_ff @(posedge clk) begin
            if (!rst_n)          ev_q[i] <= 1'b0;
            else if (ev_set[i])  ev_q[i] <= 1'b1;
            else if (ev_clr[i])  ev_q[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            ev_set[i] |=> ev_q[i]); // R7
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_clr[i] && !ev_set[i]) |=> !ev_q[i]); // R7
    end

    assign irq = |(ev_q & ev_mask);

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q == '0) |-> !irq); // R6
endmodule

// File: rtl/rx_frame_status.sv
// Module: receive frame completion status tracker (top).
// Counts frame bytes, flags oversize frames without truncating them,
//   commits a status word, then raises a maskable frame-received event.
// Assumes: stream rules as in the brief; status word needs STW >= LEN_W+3.
module rx_frame_status
    import rxst_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int DW    = 8,
    parameter int STW   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [DW-1:0]    in_data,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             mask_frame,
    input  logic             mask_babble,
    input  logic             clr_frame,
    input  logic             clr_babble,
    output logic             pass_valid,
    output logic [DW-1:0]    pass_data,
    output logic             st_wr,
    output logic [STW-1:0]   st_word,
    output logic             ev_frame,
    output logic             ev_babble,
    output logic             irq
);
    logic             beat_first, beat_more;
    logic [LEN_W-1:0] cnt_nx;
    logic             long_nx, babble_pulse, frame_done;
    logic [EV_COUNT-1:0] ev_set, ev_clr, ev_mask, ev_q;

    rxst_len_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .beat_first(beat_first), .beat_more(beat_more),
        .max_len(cfg_max_len),
        .cnt_nx(cnt_nx), .long_nx(long_nx), .babble_pulse(babble_pulse)
    );

    rxst_frame_seq #(.LEN_W(LEN_W), .STW(STW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .cnt_nx(cnt_nx), .long_nx(long_nx),
        .beat_first(beat_first), .beat_more(beat_more),
        .st_wr(st_wr), .st_word(st_word), .frame_done(frame_done)
    );

    // Route event sources, clears and masks into the event bank.
    always_comb begin
        ev_set             = '0;
        ev_clr             = '0;
        ev_mask            = '0;
        ev_set[EV_FRAME]   = frame_done;
        ev_set[EV_BABBLE]  = babble_pulse;
        ev_clr[EV_FRAME]   = clr_frame;
        ev_clr[EV_BABBLE]  = clr_babble;
        ev_mask[EV_FRAME]  = mask_frame;
        ev_mask[EV_BABBLE] = mask_babble;
    end

    rxst_events #(.N(EV_COUNT)) u_ev (
        .clk(clk), .rst_n(rst_n),
        .ev_set(ev_set), .ev_clr(ev_clr), .ev_mask(ev_mask),
        .ev_q(ev_q), .irq(irq)
    );

    assign ev_frame  = ev_q[EV_FRAME];
    assign ev_babble = ev_q[EV_BABBLE];

    // One-cycle pass-through of every accepted byte, never truncated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_valid <= 1'b0;
            pass_data  <= '0;
        end else begin
            pass_valid <= beat_first || beat_more;
            pass_data  <= in_data;
        end
    end

    AST_FRAME_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_frame) |-> $past(st_wr)); // R5
    AST_NOT_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !ev_frame) |=> ev_frame); // R5
    AST_PASS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !st_wr && !$past(in_valid && in_eof)) |=> pass_valid); // R1
endmodule

// File: tb/rx_frame_status_test.sv
module rx_frame_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic [10:0] cfg_max_len = 11'd10;
    logic        mask_frame = 1'b0, mask_babble = 1'b0;
    logic        clr_frame = 1'b0, clr_babble = 1'b0;
    logic        pass_valid, st_wr, ev_frame, ev_babble, irq;
    logic [7:0]  pass_data;
    logic [15:0] st_word;

    int errors = 0;
    int checks = 0;
    int pass_cnt = 0;
    bit chk_evf = 1'b0;
    logic [15:0] exp_q[$];

    rx_frame_status uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .cfg_max_len(cfg_max_len),
        .mask_frame(mask_frame), .mask_babble(mask_babble),
        .clr_frame(clr_frame), .clr_babble(clr_babble),
        .pass_valid(pass_valid), .pass_data(pass_data),
        .st_wr(st_wr), .st_word(st_word),
        .ev_frame(ev_frame), .ev_babble(ev_babble), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 7) + 3);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pass-through order, status scoreboard, event ordering.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pass_valid) begin
                chk(pass_data == pat(pass_cnt + 1), "R1 pass data", pass_data, pat(pass_cnt + 1));
                pass_cnt++;
            end
            if (chk_evf) begin
                chk(ev_frame == 1'b1, "R5 event after write", ev_frame, 1);
                chk_evf = 1'b0;
            end
            if (st_wr) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected status write", st_word, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(st_word == e, "R2/R4/R8 status word", st_word, e);
                end
                chk(ev_frame == 1'b0, "R5 no event with write", ev_frame, 0);
                chk_evf = 1'b1;
            end
        end
    end

    // Driver: one frame of n bytes; optional mid-frame babble clear and a
    // frame-event clear colliding with the set.
    task automatic send_frame(input int n, input int clr_b_at, input bit collide);
        int mx;
        int nsat;
        bit lng;
        bit exp_evb;
        mx   = int'(cfg_max_len);
        nsat = (n > 2047) ? 2047 : n;
        lng  = (n > mx);
        exp_evb = lng && (clr_b_at == 0);
        exp_q.push_back({2'b00, 1'b0, 1'b1, lng, 11'(nsat)});
        pass_cnt = 0;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_sof = (k == 1); in_eof = (k == n);
            in_data = pat(k); clr_babble = (k == clr_b_at);
            if (k == mx + 1) begin
                @(negedge clk);
                chk(ev_babble == 1'b0, "R3 babble not early", ev_babble, 0);
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        clr_babble = 1'b0; clr_frame = collide;
        @(posedge clk); #1;
        clr_frame = 1'b0;
        @(negedge clk);
        chk(ev_frame == 1'b1, collide ? "R7 set wins over clear" : "R5 event set", ev_frame, 1);
        chk(ev_babble == exp_evb, "R3 babble event", ev_babble, exp_evb);
        chk(pass_cnt == n, "R1 pass count", pass_cnt, n);
        chk(irq == (mask_frame | (mask_babble & exp_evb)), "R6 irq", irq,
            mask_frame | (mask_babble & exp_evb));
        @(posedge clk); #1;
        clr_frame = 1'b1; clr_babble = 1'b1;
        @(posedge clk); #1;
        clr_frame = 1'b0; clr_babble = 1'b0;
        @(negedge clk);
        chk(!ev_frame && !ev_babble, "R7 write-1 clear", {ev_frame, ev_babble}, 0);
        chk(irq == 1'b0, "R6 irq after clear", irq, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!st_wr && !pass_valid && !ev_frame && !ev_babble && !irq, "R10 reset",
            {st_wr, pass_valid, ev_frame, ev_babble, irq}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!st_wr && !pass_valid && !ev_frame && !irq, "R10 after reset",
            {st_wr, pass_valid, ev_frame, irq}, 0);

        // R2 short frame, frame event masked in
        mask_frame = 1'b1;
        send_frame(5, 0, 1'b0);
        // R2 R3 long frame, both masks
        mask_babble = 1'b1;
        send_frame(12, 0, 1'b0);
        // R3 babble cleared mid-frame must not come back
        send_frame(16, 13, 1'b0);
        // R6 masks off
        mask_frame = 1'b0; mask_babble = 1'b0;
        send_frame(14, 0, 1'b0);
        // R7 clear collides with set
        mask_frame = 1'b1;
        send_frame(4, 0, 1'b1);
        // R4 single-beat frame, limit 0 -> long
        cfg_max_len = 11'd0;
        mask_babble = 1'b1;
        send_frame(1, 0, 1'b0);
        // boundary: exactly at limit is not long
        cfg_max_len = 11'd10;
        send_frame(10, 0, 1'b0);
        send_frame(11, 0, 1'b0);

        // R9 stray beats while idle
        pass_cnt = 0;
        @(posedge clk); #1;
        in_valid = 1'b1; in_eof = 1'b1; in_data = 8'hAA;
        repeat (3) @(posedge clk);
        #1 in_valid = 1'b0; in_eof = 1'b0;
        repeat (2) @(negedge clk);
        chk(pass_cnt == 0, "R9 stray beats not passed", pass_cnt, 0);
        chk(!ev_frame && !ev_babble, "R9 stray beats no event", {ev_frame, ev_babble}, 0);
        send_frame(3, 0, 1'b0);

        // R8 saturation on a very long frame
        cfg_max_len = 11'd100;
        send_frame(2100, 0, 1'b0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all status words seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule